// File: doc/BRIEF.md
# Synchronous Serial Port with Armed Trigger

This block is an eight-bit clocked serial shifter. It can drive its own shift clock as master or follow a shift clock from outside as slave. Software loads a byte through a small register bus, picks the clock source and the interrupt mask, and then writes a trigger bit. During the transfer the byte leaves on `sdata_out`, most significant bit first, and the incoming byte fills the same register. Once eight bits have moved, the port returns to idle and raises its interrupt factor flag.

Two rules govern starting and stopping. A trigger is honoured only if the data register was written or read after the previous transfer ended or was cancelled; that access is what arms the port. Reading the factor flag while a transfer is running cancels the transfer and puts the port back in its idle state.

Register map on `bus_addr`:
- 0: shift data.
- 1: control. Bit 0 is the trigger (write only, reads 0), bit 1 selects master, bit 2 is the interrupt mask.
- 2: status. Bit 0 is the run bit.
- 3: factor flag in bit 0. Reading it clears it.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, the status bit, the factor flag, the data register, `irq` and `sdata_out` are all 0, and `sclk_out` is 1.
- R2: A write to address 1 with bit 0 set starts a transfer only if the data register (address 0) was written or read after reset, after the last transfer ended, or after the last cancel. Otherwise it has no effect and the status bit stays 0.
- R3: A trigger write made while a transfer runs has no effect. The transfer still ends after exactly eight bits.
- R4: Status bit 0 (address 2) reads 1 from the cycle after an accepted trigger until the eighth bit is sampled or the transfer is cancelled, and 0 at all other times.
- R5: In master mode (control bit 1 = 1), `sclk_out` idles high and, during a transfer, goes low for DIV_HALF system clocks and then high for DIV_HALF, eight times. `sdata_out` takes the next bit, most significant first, when the clock falls. `sdata_in` is sampled when it rises. Afterwards the data register holds the eight received bits, first received in bit 7.
- R6: In slave mode (control bit 1 = 0), `sclk_out` stays 1. Edges of `sclk_in` pass through a two-stage synchronizer and shift data with the same polarity as R5. Edges that arrive before the trigger is accepted are ignored.
- R7: The factor flag (address 3, bit 0) is set when the eighth bit is sampled, whatever the mask. `irq` is 1 exactly while both the flag and the mask (control bit 2) are 1.
- R8: A read of address 3 returns the flag and clears it. If that read happens during a transfer, the transfer is cancelled: status returns to 0, the flag is not set, `sclk_out` returns high, and a fresh data access is needed before the next trigger.
- R9: A write to the data register while a transfer runs is ignored. The received byte is not altered.
- R10: Control reads back the mask in bit 2 and the master select in bit 1. Bit 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reads of address 3 have side effects) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register, combinational |
| sclk_in | input | 1 | External shift clock used in slave mode |
| sclk_out | output | 1 | Shift clock driven in master mode, idles high |
| sdata_in | input | 1 | Serial receive data |
| sdata_out | output | 1 | Serial transmit data |
| irq | output | 1 | Interrupt request, flag gated by mask |

## Verification
The clock edge that samples a trigger write is the one that accepts it, and the status bit reads 1 from the next cycle. In master mode with DIV_HALF of 1, bit k falls out on the (2k+1)th edge after acceptance and is sampled on the (2k+2)th, so the flag and the idle status appear after the sixteenth edge. A slave edge applied on `sclk_in` acts on the third system edge after it. The bench therefore waits four edges per slave half-period and samples every result one nanosecond after the edge that is due to produce it. Side effects of a read land on the edge that ends the read, so status is checked only after that edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_CTRL = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_FLAG = 2'd3
    } reg_addr_e;

    localparam int CTRL_TRIG_BIT   = 0;
    localparam int CTRL_MASTER_BIT = 1;
    localparam int CTRL_MASK_BIT   = 2;
    localparam int CTRL_USED_W     = 3;

    typedef struct packed {
        logic master;
        logic mask;
    } ctrl_t;

    typedef struct packed {
        logic start;
        logic abort;
        logic load;
    } seq_cmd_t;

    typedef struct packed {
        logic fall;
        logic rise;
    } edge_ev_t;

    function automatic logic addr_hit(logic en, logic [1:0] addr, reg_addr_e target);
        return en && (addr == target);
    endfunction

endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
    import ssp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [1:0]             bus_addr,
    input  logic [CTRL_USED_W-1:0] ctrl_wbits,
    input  logic                   running,
    input  logic                   done,
    output ctrl_t                  ctrl,
    output logic                   flag,
    output logic                   armed,
    output seq_cmd_t               cmd
);

    logic wr_data, rd_data, wr_ctrl, rd_flag;

    always_comb begin
        wr_data   = addr_hit(bus_wr, bus_addr, ADDR_DATA);
        rd_data   = addr_hit(bus_rd, bus_addr, ADDR_DATA);
        wr_ctrl   = addr_hit(bus_wr, bus_addr, ADDR_CTRL);
        rd_flag   = addr_hit(bus_rd, bus_addr, ADDR_FLAG);
        cmd.load  = wr_data && !running;
        cmd.start = wr_ctrl && ctrl_wbits[CTRL_TRIG_BIT] && armed && !running;
        cmd.abort = rd_flag && running;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            flag  <= 1'b0;
            ctrl  <= '0;
        end else begin
            if (cmd.start || cmd.abort)
                armed <= 1'b0;
            else if ((wr_data || rd_data) && !running)
                armed <= 1'b1;

            if (done)
                flag <= 1'b1;
            else if (rd_flag)
                flag <= 1'b0;

            if (wr_ctrl) begin
                ctrl.master <= ctrl_wbits[CTRL_MASTER_BIT];
                ctrl.mask   <= ctrl_wbits[CTRL_MASK_BIT];
            end
        end
    end

endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int DIV_HALF = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     running,
    input  logic     master,
    input  logic     sclk_in,
    output edge_ev_t ev,
    output logic     sclk_out
);

    localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam int SYNC_N = 3;

    logic [DIV_W-1:0]  divcnt;
    logic              sclk_q;
    logic [SYNC_N-1:0] sync_q;
    logic              tick;
    logic              slave_run;

    assign tick      = running && master && (divcnt == DIV_W'(DIV_HALF - 1));
    assign slave_run = running && !master;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], sclk_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !running || !master) begin
            sclk_q <= 1'b1;
            divcnt <= '0;
        end else if (tick) begin
            sclk_q <= ~sclk_q;
            divcnt <= '0;
        end else begin
            divcnt <= divcnt + 1'b1;
        end
    end

    always_comb begin
        if (master) begin
            ev.fall = tick && sclk_q;
            ev.rise = tick && !sclk_q;
        end else begin
            ev.fall = slave_run && sync_q[SYNC_N-1] && !sync_q[SYNC_N-2];
            ev.rise = slave_run && !sync_q[SYNC_N-1] && sync_q[SYNC_N-2];
        end
    end

    assign sclk_out = sclk_q;

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_cmd_t          cmd,
    input  edge_ev_t          ev,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sdata_in,
    output logic              running,
    output logic              done,
    output logic [DATA_W-1:0] sreg,
    output logic              sdata_out
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [CNT_W-1:0] bitcnt;
    logic             last_bit;

    assign last_bit = (bitcnt == CNT_W'(DATA_W - 1));
    assign done     = running && !cmd.abort && ev.rise && last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            bitcnt    <= '0;
            sreg      <= '0;
            sdata_out <= 1'b0;
        end else begin
            if (cmd.load)
                sreg <= wdata;

            if (cmd.abort) begin
                running <= 1'b0;
                bitcnt  <= '0;
            end else if (cmd.start) begin
                running <= 1'b1;
                bitcnt  <= '0;
            end else if (running) begin
                if (ev.fall)
                    sdata_out <= sreg[DATA_W-1];
                if (ev.rise) begin
                    sreg   <= {sreg[DATA_W-2:0], sdata_in};
                    bitcnt <= bitcnt + 1'b1;
                    if (last_bit)
                        running <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_HALF = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sclk_in,
    output logic              sclk_out,
    input  logic              sdata_in,
    output logic              sdata_out,
    output logic              irq
);

    ctrl_t             ctrl;
    seq_cmd_t          cmd;
    edge_ev_t          ev;
    logic              flag, armed, running, done;
    logic [DATA_W-1:0] sreg;
    logic              start_pulse, abort_pulse;

    assign start_pulse = cmd.start;
    assign abort_pulse = cmd.abort;

    ssp_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .ctrl_wbits (bus_wdata[CTRL_USED_W-1:0]),
        .running    (running),
        .done       (done),
        .ctrl       (ctrl),
        .flag       (flag),
        .armed      (armed),
        .cmd        (cmd)
    );

    ssp_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .running  (running),
        .master   (ctrl.master),
        .sclk_in  (sclk_in),
        .ev       (ev),
        .sclk_out (sclk_out)
    );

    ssp_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .ev        (ev),
        .wdata     (bus_wdata),
        .sdata_in  (sdata_in),
        .running   (running),
        .done      (done),
        .sreg      (sreg),
        .sdata_out (sdata_out)
    );

    always_comb begin
        case (reg_addr_e'(bus_addr))
            ADDR_DATA: bus_rdata = sreg;
            ADDR_CTRL: bus_rdata = {{(DATA_W-3){1'b0}}, ctrl.mask, ctrl.master, 1'b0};
            ADDR_STAT: bus_rdata = {{(DATA_W-1){1'b0}}, running};
            default:   bus_rdata = {{(DATA_W-1){1'b0}}, flag};
        endcase
    end

    assign irq = flag && ctrl.mask;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic clk,
    input logic rst,
    input logic running,
    input logic armed,
    input logic start_pulse,
    input logic abort_pulse,
    input logic done,
    input logic flag,
    input logic sclk_out
);

    AST_RUN_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst) $rose(running) |-> $past(armed)); // R2
    AST_NO_ARM_IN_RUN: assert property (@(posedge clk) disable iff (rst) running |-> !armed); // R2
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst) ($past(running) && !$past(abort_pulse) && !$past(done)) |-> running); // R4
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst) start_pulse |=> running); // R3
    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst) done |=> (flag && !running)); // R7
    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst) abort_pulse |=> (!running && !flag)); // R8
    AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst) (!running && !$past(running)) |-> sclk_out); // R5

endmodule

bind sync_serial_port ssp_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .running     (running),
    .armed       (armed),
    .start_pulse (start_pulse),
    .abort_pulse (abort_pulse),
    .done        (done),
    .flag        (flag),
    .sclk_out    (sclk_out)
);

// File: tb/sync_serial_port_tb_top.sv
module sync_serial_port_tb_top;

    localparam int DW = 8;
    localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2, A_FLAG = 2'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          sclk_in = 1'b1, sdata_in = 1'b0;
    logic          sclk_out, sdata_out, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sync_serial_port #(.DATA_W(DW), .DIV_HALF(1)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sdata_in(sdata_in), .sdata_out(sdata_out), .irq(irq)
    );

    function automatic logic [DW-1:0] ctrl_word(logic trig, logic master, logic mask);
        return {{(DW-3){1'b0}}, mask, master, trig};
    endfunction

    function automatic logic exp_irq(logic flag_v, logic mask_v);
        return flag_v & mask_v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic peek_status(string req, logic exp);
        bus_addr = A_STAT;
        #1 check(req, bus_rdata[0], exp);
    endtask

    task automatic master_xfer(logic [DW-1:0] tx, logic [DW-1:0] rx, logic mask, bit inject);
        logic [DW-1:0] rd;
        bus_write(A_DATA, tx);
        bus_write(A_CTRL, ctrl_word(1'b1, 1'b1, mask));
        peek_status("R4 status after trigger", 1'b1);
        for (int i = 0; i < DW; i++) begin
            @(posedge clk); #1;
            check("R5 sclk low phase", sclk_out, 1'b0);
            check("R5 msb-first out", sdata_out, tx[DW-1-i]);
            sdata_in = rx[DW-1-i];
            if (inject && i == 2) begin
                bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = ctrl_word(1'b1, 1'b1, mask); // R3
            end
            if (inject && i == 4) begin
                bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = ~tx; // R9
            end
            @(posedge clk); #1;
            bus_wr = 1'b0;
            check("R5 sclk high phase", sclk_out, 1'b1);
            if (i < DW - 1) peek_status("R3 R4 still running", 1'b1);
        end
        peek_status("R4 idle after eighth bit", 1'b0);
        check("R7 irq gated by mask", irq, exp_irq(1'b1, mask));
        bus_read(A_FLAG, rd);
        check("R7 flag set at end", rd[0], 1'b1);
        check("R8 irq cleared by flag read", irq, 1'b0);
        bus_read(A_DATA, rd);
        check(inject ? "R9 received byte intact" : "R5 received byte", rd, rx);
    endtask

    task automatic slave_xfer(logic [DW-1:0] tx, logic [DW-1:0] rx, logic mask);
        logic [DW-1:0] rd;
        bus_write(A_DATA, tx);
        bus_write(A_CTRL, ctrl_word(1'b0, 1'b0, mask));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); sclk_in = 1'b0; repeat (4) @(posedge clk);
            @(negedge clk); sclk_in = 1'b1; repeat (4) @(posedge clk);
        end
        bus_write(A_CTRL, ctrl_word(1'b1, 1'b0, mask));
        peek_status("R6 early edges ignored, run started", 1'b1);
        for (int i = 0; i < DW; i++) begin
            @(negedge clk); sclk_in = 1'b0;
            repeat (4) @(posedge clk); #1;
            check("R6 slave msb-first out", sdata_out, tx[DW-1-i]);
            check("R6 sclk_out held high", sclk_out, 1'b1);
            sdata_in = rx[DW-1-i];
            @(negedge clk); sclk_in = 1'b1;
            repeat (4) @(posedge clk); #1;
            if (i < DW - 1) peek_status("R6 running until eighth edge", 1'b1);
        end
        peek_status("R6 idle after eighth edge", 1'b0);
        bus_read(A_FLAG, rd);
        check("R7 slave flag", rd[0], 1'b1);
        bus_read(A_DATA, rd);
        check("R6 slave received byte", rd, rx);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] rd;
        int unsigned seed_val;
        seed_val = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        #1;
        check("R1 sclk_out idle", sclk_out, 1'b1);
        check("R1 sdata_out", sdata_out, 1'b0);
        check("R1 irq", irq, 1'b0);
        peek_status("R1 status", 1'b0);
        bus_read(A_FLAG, rd); check("R1 flag", rd, '0);

        // R2 unarmed trigger has no effect
        bus_write(A_CTRL, ctrl_word(1'b1, 1'b1, 1'b1));
        peek_status("R2 unarmed trigger ignored", 1'b0);
        repeat (3) @(posedge clk); #1;
        check("R2 no clock without arm", sclk_out, 1'b1);

        // R10 control readback (also R1 data register reset value)
        bus_read(A_CTRL, rd); check("R10 control readback", rd, 8'h06);
        bus_read(A_DATA, rd); check("R1 data reset", rd, '0);

        // directed master transfers
        master_xfer(8'hA5, 8'h3C, 1'b1, 1'b0);
        master_xfer(8'h80, 8'h01, 1'b0, 1'b1);

        // R8 abort by flag read, then re-arm rule
        bus_write(A_DATA, 8'h5A);
        bus_write(A_CTRL, ctrl_word(1'b1, 1'b1, 1'b1));
        repeat (5) @(posedge clk);
        bus_read(A_FLAG, rd);
        check("R8 flag read during run returns 0", rd[0], 1'b0);
        peek_status("R8 abort stops run", 1'b0);
        repeat (2) @(posedge clk); #1;
        check("R8 sclk back high", sclk_out, 1'b1);
        repeat (20) @(posedge clk);
        bus_read(A_FLAG, rd);
        check("R8 no flag after abort", rd[0], 1'b0);
        bus_write(A_CTRL, ctrl_word(1'b1, 1'b1, 1'b1));
        peek_status("R8 R2 trigger needs re-arm", 1'b0);
        bus_read(A_DATA, rd);
        bus_write(A_CTRL, ctrl_word(1'b1, 1'b1, 1'b1));
        peek_status("R2 read of data arms", 1'b1);
        repeat (20) @(posedge clk);
        bus_read(A_FLAG, rd);
        check("R7 flag after read-armed run", rd[0], 1'b1);

        // slave transfers
        slave_xfer(8'hC3, 8'h96, 1'b1);
        slave_xfer(8'h01, 8'hFE, 1'b0);

        // random master transfers
        for (int n = 0; n < 8; n++) begin
            master_xfer(DW'($urandom), DW'($urandom), 1'($urandom), (n % 2) == 1);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule